// File: doc/BRIEF.md
# Serial Command Word Receiver with Cascade Output

This block is the serial receive side of a command-driven peripheral. A host lowers an active-low chip select, toggles a serial clock and presents one data bit per clock. The block gathers those bits into a 16-bit word, most significant bit first: the top four bits are the control field and the lower twelve are the data field. When chip select returns high, the block hands the word to the command logic together with a one-cycle strobe. Decoding the word is done elsewhere.

The serial pins are sampled by a fast system clock through synchronizer stages and edge detectors. A parameter can set the stage count to zero when the pins are already synchronous to the system clock. Serial-clock rising edges shift data in. Serial-clock falling edges launch the oldest bit of the shift register onto a serial output. Several devices can therefore share one clock and one chip select, each output feeding the next device's input. The serial output floats whenever chip select is high. It is modelled as an output-enable flop plus a tri-state driver.

Top module: `serial_cmd_frontend`

## Requirements
- R1: While reset is high and in the first cycle after it, word_o is 0, word_valid_o is 0 and sdo_oe_o is 0. The data launched on sdo_o before the first falling edge is 0.
- R2: A bit is shifted in only on a rising edge of sclk_i seen while csn_i is low. The first of the last 16 bits lands in word_o bit 15, so the control field is word_o[15:12] and the data field is word_o[11:0].
- R3: Rising edges of sclk_i while csn_i is high leave the shift contents unchanged. Bits sent then never show up in a later word or on sdo_o.
- R4: Every rising edge of csn_i produces exactly one word_valid_o pulse, one system cycle long, and word_o holds the captured word in that cycle.
- R5: If a frame has other than 16 clocks, the word passed on is the last 16 bits shifted in, including bits left over from earlier frames. A frame of zero clocks re-issues the previous contents.
- R6: sdo_o changes only after a falling edge of sclk_i while csn_i is low. A bit sampled on a rising edge is driven from the falling edge after the fifteenth later rising edge. A downstream device therefore samples it on the seventeenth rising edge, counting the sampling edge as the first.
- R7: sdo_oe_o is high while the synchronized csn_i is low and low while it is high. sdo_o is driven only when sdo_oe_o is high and is high impedance otherwise.
- R8: With two devices chained and csn_i held low for 32 clocks, the second device captures the first 16-bit word sent and the first device captures the second word.
- R9: word_valid_o rises SYNC_STAGES+1 system clocks after the system-clock edge at which csn_i is first seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial cascade output, high impedance when disabled |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| word_o | output | WORD_W | Last captured word, bit 15 first received |
| word_valid_o | output | 1 | One-cycle strobe when a word is captured |

## Verification
The assertions assume that every high and low phase of sclk_i lasts longer than the synchronizer latency plus one system cycle. They also assume that csn_i changes only while sclk_i is low. Under those conditions each serial edge is seen exactly once, and a frame boundary never coincides with a shift. The bench drives every serial phase for six system clocks with two synchronizer stages, and it moves chip select only after a falling edge has fully settled. It sweeps frame lengths from 0 to 20 bits, with ignored toggles between frames. It finishes with a two-device chain.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  typedef struct packed {
    logic csn;
    logic sclk;
    logic sdi;
  } pin_set_t;

  localparam pin_set_t PIN_IDLE = '{csn: 1'b1, sclk: 1'b0, sdi: 1'b0};
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int            STAGES  = 2,
  parameter int            W       = 3,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sfe_edge.sv
module sfe_edge
  import sfe_pkg::*;
#(
  parameter logic IDLE = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  output edge_evt_t evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= lvl;
  end

  assign evt.rise = lvl & ~prev_q;
  assign evt.fall = ~lvl & prev_q;
endmodule

// File: rtl/sfe_shift.sv
module sfe_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_i,
  input  logic              capture,
  output logic [WORD_W-1:0] shreg_o,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_o <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= capture;
      if (shift_en) shreg_o <= {shreg_o[WORD_W-2:0], bit_i};
      if (capture)  word_o  <= shreg_o;
    end
  end
endmodule

// File: rtl/sfe_dout.sv
module sfe_dout (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic bit_i,
  input  logic drive_en,
  output logic data_q,
  output logic oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= drive_en;
      if (load) data_q <= bit_i;
    end
  end
endmodule

// File: rtl/serial_cmd_frontend.sv
module serial_cmd_frontend
  import sfe_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int PIN_W = $bits(pin_set_t);

  pin_set_t    pins_raw;
  pin_set_t    pins_s;
  edge_evt_t   sclk_evt;
  edge_evt_t   csn_evt;
  logic        csn_s;
  logic        sclk_fall;
  logic        shift_en;
  logic        launch;
  logic        sdo_data;
  logic [WORD_W-1:0] sh_reg;

  assign pins_raw = '{csn: csn_i, sclk: sclk_i, sdi: sdi_i};

  sfe_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PIN_W),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  sfe_edge #(.IDLE(1'b0)) u_sclk_edge (
    .clk(clk), .rst(rst), .lvl(pins_s.sclk), .evt(sclk_evt)
  );

  sfe_edge #(.IDLE(1'b1)) u_csn_edge (
    .clk(clk), .rst(rst), .lvl(pins_s.csn), .evt(csn_evt)
  );

  assign csn_s     = pins_s.csn;
  assign sclk_fall = sclk_evt.fall;
  assign shift_en  = sclk_evt.rise & ~csn_s;
  assign launch    = sclk_evt.fall & ~csn_s;

  sfe_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(shift_en),
    .bit_i   (pins_s.sdi),
    .capture (csn_evt.rise),
    .shreg_o (sh_reg),
    .word_o  (word_o),
    .valid_o (word_valid_o)
  );

  sfe_dout u_dout (
    .clk     (clk),
    .rst     (rst),
    .load    (launch),
    .bit_i   (sh_reg[WORD_W-1]),
    .drive_en(~csn_s),
    .data_q  (sdo_data),
    .oe_q    (sdo_oe_o)
  );

  assign sdo_o = sdo_oe_o ? sdo_data : 1'bz;
endmodule

// File: rtl/serial_cmd_frontend_chk.sv
module serial_cmd_frontend_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              word_valid,
  input logic              oe,
  input logic              cs_idle,
  input logic              sclk_fall,
  input logic              sdo_data,
  input logic [WORD_W-1:0] sh_reg
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!word_valid && !oe));

  // R4
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R7
  a_r7_released_at_capture: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !oe);

  // R3
  a_r3_hold_while_idle: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> $stable(sh_reg));

  // R6
  a_r6_launch_on_fall: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(sdo_data));
endmodule

bind serial_cmd_frontend serial_cmd_frontend_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_valid(word_valid_o),
  .oe        (sdo_oe_o),
  .cs_idle   (csn_s),
  .sclk_fall (sclk_fall),
  .sdo_data  (sdo_data),
  .sh_reg    (sh_reg)
);

// File: tb/test_serial_cmd_frontend.sv
module test_serial_cmd_frontend;
  localparam int W    = 16;
  localparam int SYNC = 2;
  localparam int H    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csn = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;

  wire         sdo_a, oe_a, vld_a, sdo_b, oe_b, vld_b;
  wire [W-1:0] word_a, word_b;

  int n_chk = 0;
  int n_err = 0;

  logic [W-1:0] mshift = '0;
  logic         msdo   = 1'b0;

  always #2 clk = ~clk;

  serial_cmd_frontend #(.WORD_W(W), .SYNC_STAGES(SYNC)) i_serial_cmd_frontend (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo_a), .sdo_oe_o(oe_a), .word_o(word_a), .word_valid_o(vld_a)
  );

  serial_cmd_frontend #(.WORD_W(W), .SYNC_STAGES(SYNC)) i_serial_cmd_frontend_nxt (
    .clk(clk), .rst(rst), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdo_a),
    .sdo_o(sdo_b), .sdo_oe_o(oe_b), .word_o(word_b), .word_valid_o(vld_b)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit in_frame);
    sdi = b;
    repeat (H) @(negedge clk);
    if (in_frame) check(sdo_a === msdo, "R6 sdo bit", {31'd0, sdo_a}, {31'd0, msdo});
    sclk = 1'b1;
    if (in_frame) mshift = {mshift[W-2:0], b};
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    if (in_frame) msdo = mshift[W-1];
  endtask

  task automatic open_frame();
    csn = 1'b0;
    repeat (H) @(negedge clk);
    check(oe_a === 1'b1, "R7 enable low cs", {31'd0, oe_a}, 32'd1);
  endtask

  task automatic close_frame();
    int pulses;
    int at;
    logic [W-1:0] got;
    pulses = 0; at = 0; got = '0;
    repeat (H) @(negedge clk);
    csn = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (vld_a === 1'b1) begin
        pulses++;
        at  = k;
        got = word_a;
      end
    end
    check(pulses == 1, "R4 pulse count", pulses, 1);
    check(at == SYNC + 1, "R9 strobe latency", at, SYNC + 1);
    check(got === mshift, "R2 R5 captured word", {16'd0, got}, {16'd0, mshift});
    check(oe_a === 1'b0, "R7 release high cs", {31'd0, oe_a}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    check(word_a === '0 && vld_a === 1'b0 && oe_a === 1'b0, "R1 in reset",
          {word_a, 13'd0, vld_a, oe_a, 1'b0}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(word_a === '0 && vld_a === 1'b0 && oe_a === 1'b0, "R1 after reset",
          {word_a, 13'd0, vld_a, oe_a, 1'b0}, 32'd0);

    // R2 R3 R5 R6: sweep frame lengths with ignored toggles between frames
    for (int len = 0; len <= 20; len++) begin
      pat = 32'h9A5C_36E1 ^ (32'h0101_3579 * len);
      open_frame();
      for (int i = 0; i < len; i++) send_bit(pat[31 - i], 1'b1);
      close_frame();
      for (int i = 0; i < 5; i++) send_bit(~pat[i], 1'b0);  // R3 ignored bits
    end

    // R2: field layout of an exact 16-bit frame
    open_frame();
    for (int i = 0; i < W; i++) send_bit(pat_word(4'hB, 12'h3C5, i), 1'b1);
    close_frame();
    check(word_a[15:12] === 4'hB, "R2 control field", {28'd0, word_a[15:12]}, 32'hB);
    check(word_a[11:0] === 12'h3C5, "R2 data field", {20'd0, word_a[11:0]}, 32'h3C5);

    // R8: two chained devices, 32 clocks under one chip select
    open_frame();
    for (int i = 0; i < W; i++) send_bit(pat_word(4'h9, 12'hE27, i), 1'b1);
    for (int i = 0; i < W; i++) send_bit(pat_word(4'h4, 12'h1D8, i), 1'b1);
    close_frame();
    check(word_a === 16'h41D8, "R8 first device word", {16'd0, word_a}, 32'h41D8);
    check(word_b === 16'h9E27, "R8 second device word", {16'd0, word_b}, 32'h9E27);
    check(oe_b === 1'b0, "R7 second released", {31'd0, oe_b}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  function automatic logic pat_word(input logic [3:0] c, input logic [11:0] d, input int i);
    logic [W-1:0] w;
    w = {c, d};
    return w[W-1-i];
  endfunction
endmodule